// File: doc/BRIEF.md
# Address-Filtering Nine-Bit Serial Receiver

This block receives asynchronous serial characters from a single line and presents each accepted character as a beat on a valid/ready output stream. A character is a low start bit, eight data bits least significant first, an optional ninth bit and one or two high stop bits. The line is oversampled by an external 16x tick that this block does not generate. The start bit is confirmed at its midpoint, and every later bit is sampled at its own midpoint.

With the ninth bit enabled, several nodes can share one line. A character whose ninth bit is 1 carries an address. When hardware filtering is on, an address character updates a "selected" flag: a match against the node address register sets the flag and any other address clears it. Address characters are used up by the filter and never reach the stream. Characters whose ninth bit is 0 pass only while the flag is set. When filtering is off, every character passes and its ninth bit is shown beside the data, so that software can do the filtering.

The output stream holds one beat. `rx_valid` stays high with `rx_data` and `rx_bit9` unchanged until the sink asserts `rx_ready`. A character that completes while a beat is still waiting is discarded. A bad stop bit raises a one-cycle `frame_err` pulse and the character is dropped.

Top module: `mp_uart_rx`

## Requirements
- R1: With `cfg_nine` low, a character of start, 8 data bits LSB first and stop bits is delivered with `rx_data` equal to the byte and `rx_bit9` equal to 0.
- R2: With `cfg_nine` high and `cfg_filter` low, every character is delivered, and `rx_bit9` carries the bit received after data bit 7.
- R3: With `cfg_nine` and `cfg_filter` high, an address character (ninth bit 1) whose byte equals `node_addr` selects the node and is not delivered. Data characters (ninth bit 0) that follow are delivered.
- R4: An address character whose byte differs from `node_addr` deselects the node and is not delivered. Data characters that follow are dropped.
- R5: After reset the node is deselected, so data characters are dropped in filter mode until a matching address arrives.
- R6: With `cfg_two_stop` high, both stop positions are checked and a correct two-stop character is delivered. With it low, only the first stop position is checked.
- R7: A low level in any checked stop position gives a `frame_err` pulse of exactly one cycle. The character is not delivered and the selected flag is unchanged. A new start is accepted only after the line has been seen high again.
- R8: A low pulse on an idle line that is high again at the start-bit midpoint (8 ticks after the falling edge) produces no character and no error.
- R9: While `rx_valid` is high and `rx_ready` is low, `rx_valid`, `rx_data` and `rx_bit9` hold steady. A character completed in that state is discarded.
- R10: After reset `rx_valid` and `frame_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial input; idles high |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| cfg_nine | input | 1 | Ninth bit present after data bit 7 |
| cfg_filter | input | 1 | Hardware address filtering (used when `cfg_nine` is high) |
| cfg_two_stop | input | 1 | Expect two stop bits |
| node_addr | input | 8 | Address of this node |
| rx_valid | output | 1 | Output beat available |
| rx_ready | input | 1 | Sink accepts the beat |
| rx_data | output | 8 | Received byte |
| rx_bit9 | output | 1 | Received ninth bit (0 when `cfg_nine` is low) |
| frame_err | output | 1 | One-cycle pulse on a bad stop bit |

## Verification
The hardest state to reach from the ports is a framing error that lands while the node is selected, followed by a check that the selection survived. The stimulus first selects the node with a matching address character. It then sends a non-matching address character with a low second stop bit, which would deselect the node if the error were ignored. A data character sent afterwards must still be delivered. The discard-on-full case is reached by holding `rx_ready` low across two whole characters and then checking that only the first one comes out.

// File: rtl/mprx_pkg.sv
package mprx_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_NINTH,
    ST_STOP1,
    ST_STOP2
  } rx_state_t;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              ninth;
    logic              ferr;
  } frame_t;
endpackage

// File: rtl/mprx_frame_engine.sv
module mprx_frame_engine
  import mprx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   rx_in,
  input  logic   tick,
  input  logic   nine_en,
  input  logic   two_stop,
  output frame_t frame_o,
  output logic   done_o
);
  localparam int unsigned CW  = $clog2(OVS);
  localparam int unsigned IW  = $clog2(BYTE_W);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [IW-1:0] TOP  = IW'(BYTE_W - 1);

  logic              rx_meta, rx_s;
  rx_state_t         st;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     idx;
  logic [BYTE_W-1:0] shreg;
  logic              ninth_q, ferr_q, armed;

  // two-stage synchroniser for the asynchronous line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_meta <= 1'b1;
      rx_s    <= 1'b1;
    end else begin
      rx_meta <= rx_in;
      rx_s    <= rx_meta;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      idx     <= '0;
      shreg   <= '0;
      ninth_q <= 1'b0;
      ferr_q  <= 1'b0;
      armed   <= 1'b0;
      done_o  <= 1'b0;
      frame_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (tick) begin
        unique case (st)
          ST_IDLE: begin
            if (rx_s) begin
              armed <= 1'b1;
            end else if (armed) begin
              st      <= ST_START;
              cnt     <= '0;
              ninth_q <= 1'b0;
              ferr_q  <= 1'b0;
            end
          end
          ST_START: begin
            if (cnt == MID) begin
              cnt <= '0;
              idx <= '0;
              st  <= rx_s ? ST_IDLE : ST_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (cnt == LAST) begin
              cnt   <= '0;
              shreg <= {rx_s, shreg[BYTE_W-1:1]};
              if (idx == TOP) st <= nine_en ? ST_NINTH : ST_STOP1;
              else            idx <= idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_NINTH: begin
            if (cnt == LAST) begin
              cnt     <= '0;
              ninth_q <= rx_s;
              st      <= ST_STOP1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP1: begin
            if (cnt == LAST) begin
              cnt <= '0;
              if (two_stop) begin
                ferr_q <= ~rx_s;
                st     <= ST_STOP2;
              end else begin
                st      <= ST_IDLE;
                armed   <= 1'b0;
                done_o  <= 1'b1;
                frame_o <= '{data: shreg, ninth: ninth_q, ferr: ~rx_s};
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP2: begin
            if (cnt == LAST) begin
              cnt     <= '0;
              st      <= ST_IDLE;
              armed   <= 1'b0;
              done_o  <= 1'b1;
              frame_o <= '{data: shreg, ninth: ninth_q, ferr: ferr_q | ~rx_s};
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mprx_addr_filter.sv
module mprx_addr_filter
  import mprx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  frame_t            frame,
  input  logic              nine_en,
  input  logic              filt_en,
  input  logic [BYTE_W-1:0] addr,
  output logic              deliver,
  output logic              bit9,
  output logic              err_pulse,
  output logic              selected
);
  logic filtering, is_addr, good;

  always_comb begin
    filtering = nine_en & filt_en;
    is_addr   = filtering & frame.ninth;
    good      = done & ~frame.ferr;
    deliver   = good & (~filtering | (~frame.ninth & selected));
    bit9      = nine_en & frame.ninth;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selected  <= 1'b0;
      err_pulse <= 1'b0;
    end else begin
      err_pulse <= done & frame.ferr;
      if (good && is_addr) selected <= (frame.data == addr);
    end
  end
endmodule

// File: rtl/mprx_out_stage.sv
module mprx_out_stage
  import mprx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_bit9,
  input  logic              ready,
  output logic              valid,
  output logic [BYTE_W-1:0] data,
  output logic              bit9
);
  logic free;
  assign free = ~valid | ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
      bit9  <= 1'b0;
    end else if (free) begin
      valid <= load;
      if (load) begin
        data <= in_data;
        bit9 <= in_bit9;
      end
    end
  end
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
  import mprx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              os_tick,
  input  logic              cfg_nine,
  input  logic              cfg_filter,
  input  logic              cfg_two_stop,
  input  logic [BYTE_W-1:0] node_addr,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              frame_err
);
  frame_t eng_frame;
  logic   eng_done, pass, pass_bit9, sel_q;

  mprx_frame_engine #(.OVS(OVS)) u_engine (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_line), .tick(os_tick),
    .nine_en(cfg_nine), .two_stop(cfg_two_stop),
    .frame_o(eng_frame), .done_o(eng_done)
  );

  mprx_addr_filter u_filter (
    .clk(clk), .rst_n(rst_n), .done(eng_done), .frame(eng_frame),
    .nine_en(cfg_nine), .filt_en(cfg_filter), .addr(node_addr),
    .deliver(pass), .bit9(pass_bit9), .err_pulse(frame_err), .selected(sel_q)
  );

  mprx_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .load(pass), .in_data(eng_frame.data),
    .in_bit9(pass_bit9), .ready(rx_ready),
    .valid(rx_valid), .data(rx_data), .bit9(rx_bit9)
  );
endmodule

// File: rtl/mprx_checker.sv
module mprx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_nine,
  input logic       cfg_filter,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data,
  input logic       rx_bit9,
  input logic       frame_err,
  input logic       eng_done,
  input logic       eng_ninth,
  input logic       eng_ferr,
  input logic       sel_q
);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data) && $stable(rx_bit9));

  a_r7_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);

  a_r7_err_not_delivered: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !$rose(rx_valid));

  a_r7_sel_kept: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done && eng_ferr |=> $stable(sel_q));

  a_r1_bit9_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_nine) && $rose(rx_valid) |-> !rx_bit9);

  a_r5_drop_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done && cfg_nine && cfg_filter && !eng_ninth && !sel_q |=> !$rose(rx_valid));

  a_r3_addr_not_delivered: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done && cfg_nine && cfg_filter && eng_ninth |=> !$rose(rx_valid));
endmodule

bind mp_uart_rx mprx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_nine(cfg_nine), .cfg_filter(cfg_filter),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_bit9(rx_bit9),
  .frame_err(frame_err), .eng_done(eng_done), .eng_ninth(eng_frame.ninth),
  .eng_ferr(eng_frame.ferr), .sel_q(sel_q)
);

// File: tb/mp_uart_rx_test.sv
module mp_uart_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLKS   = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       os_tick;
  logic       cfg_nine = 1'b0, cfg_filter = 1'b0, cfg_two_stop = 1'b0;
  logic [7:0] node_addr = 8'h5A;
  logic       rx_valid, rx_ready = 1'b0, rx_bit9, frame_err;
  logic [7:0] rx_data;
  logic [1:0] tdiv = '0;
  int         ferr_seen = 0;
  int         checks = 0, errors = 0;
  bit         finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) tdiv <= tdiv + 1'b1;
  assign os_tick = (tdiv == 2'(TICK_DIV - 1));
  always @(posedge clk) if (frame_err) ferr_seen <= ferr_seen + 1;

  mp_uart_rx uut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
    .cfg_nine(cfg_nine), .cfg_filter(cfg_filter), .cfg_two_stop(cfg_two_stop),
    .node_addr(node_addr), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .frame_err(frame_err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    rx_line = b;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  // stop_ok[0] is the first stop position, stop_ok[1] the second
  task automatic send(input logic [7:0] b, input logic ninth, input logic [1:0] stop_ok);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
    if (cfg_nine) send_bit(ninth);
    send_bit(stop_ok[0]);
    if (cfg_two_stop) send_bit(stop_ok[1]);
    send_bit(1'b1);
    send_bit(1'b1);
  endtask

  task automatic expect_beat(input logic [7:0] d, input logic n, input string tag);
    check(rx_valid === 1'b1, {tag, " valid"}, rx_valid, 1);
    check(rx_data === d, {tag, " data"}, rx_data, d);
    check(rx_bit9 === n, {tag, " bit9"}, rx_bit9, n);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    check(rx_valid === 1'b0, {tag, " consumed"}, rx_valid, 0);
  endtask

  task automatic expect_none(input string tag);
    check(rx_valid === 1'b0, {tag, " nothing delivered"}, rx_valid, 0);
  endtask

  task automatic t_reset();
    check(rx_valid === 1'b0, "R10 valid after reset", rx_valid, 0);
    check(frame_err === 1'b0, "R10 frame_err after reset", frame_err, 0);
  endtask

  task automatic t_plain();
    cfg_nine = 0; cfg_filter = 0; cfg_two_stop = 0;
    send(8'hA5, 1'b0, 2'b11); expect_beat(8'hA5, 1'b0, "R1 A5");
    send(8'h3C, 1'b0, 2'b11); expect_beat(8'h3C, 1'b0, "R1 3C");
    send(8'h01, 1'b0, 2'b11); expect_beat(8'h01, 1'b0, "R1 01 lsb first");
  endtask

  task automatic t_raw_nine();
    cfg_nine = 1; cfg_filter = 0;
    send(8'h12, 1'b1, 2'b11); expect_beat(8'h12, 1'b1, "R2 address shown");
    send(8'h34, 1'b0, 2'b11); expect_beat(8'h34, 1'b0, "R2 data shown");
  endtask

  task automatic t_filter();
    cfg_nine = 1; cfg_filter = 1;
    send(8'h11, 1'b0, 2'b11); expect_none("R5 unselected data");
    send(8'h5A, 1'b1, 2'b11); expect_none("R3 matching address consumed");
    send(8'h22, 1'b0, 2'b11); expect_beat(8'h22, 1'b0, "R3 selected data");
    send(8'h33, 1'b1, 2'b11); expect_none("R4 other address consumed");
    send(8'h44, 1'b0, 2'b11); expect_none("R4 deselected data");
  endtask

  task automatic t_stops();
    int base;
    cfg_nine = 0; cfg_filter = 0; cfg_two_stop = 1;
    send(8'h77, 1'b0, 2'b11); expect_beat(8'h77, 1'b0, "R6 two stops good");
    base = ferr_seen;
    send(8'h78, 1'b0, 2'b01); expect_none("R6 bad second stop");
    check(ferr_seen == base + 1, "R6 second stop error", ferr_seen - base, 1);
    cfg_two_stop = 0;
    base = ferr_seen;
    send(8'h79, 1'b0, 2'b10); expect_none("R7 bad single stop");
    check(ferr_seen == base + 1, "R7 single stop error", ferr_seen - base, 1);
  endtask

  task automatic t_err_keeps_sel();
    int base;
    cfg_nine = 1; cfg_filter = 1; cfg_two_stop = 1;
    send(8'h5A, 1'b1, 2'b11); expect_none("R7 select");
    base = ferr_seen;
    send(8'h99, 1'b1, 2'b01); expect_none("R7 errored address");
    check(ferr_seen == base + 1, "R7 errored address flagged", ferr_seen - base, 1);
    send(8'h55, 1'b0, 2'b11); expect_beat(8'h55, 1'b0, "R7 selection kept");
    cfg_two_stop = 0;
  endtask

  task automatic t_glitch();
    int base;
    cfg_nine = 0; cfg_filter = 0;
    base = ferr_seen;
    rx_line = 1'b0;
    repeat (4 * TICK_DIV) @(negedge clk);
    rx_line = 1'b1;
    repeat (14 * BIT_CLKS) @(negedge clk);
    expect_none("R8 glitch");
    check(ferr_seen == base, "R8 glitch no error", ferr_seen - base, 0);
  endtask

  task automatic t_backpressure();
    logic [7:0] held;
    cfg_nine = 1; cfg_filter = 0;
    send(8'hC3, 1'b1, 2'b11);
    held = rx_data;
    send(8'h0F, 1'b0, 2'b11);
    check(rx_valid === 1'b1 && rx_data === held, "R9 held under backpressure", rx_data, held);
    expect_beat(8'hC3, 1'b1, "R9 first beat");
    expect_none("R9 second discarded");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk);
    t_reset();
    t_plain();
    t_raw_nine();
    t_filter();
    t_stops();
    t_err_keeps_sel();
    t_glitch();
    t_backpressure();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule